// File: doc/BRIEF.md
# Prioritized Interrupt Arbitration Controller

This block selects one interrupt request from several inputs and presents it to a CPU. The inputs are sixteen level-sensitive external lines, a set of internal peripheral request lines and one debug request. Each source gets a 4-bit priority. The external lines do not have one field each. Lines 0 to 7 share one priority field and lines 8 to 15 share another. Each peripheral line has a field of its own. The debug source is fixed at level 15.

Every cycle the block finds the active source with the highest nonzero level and compares that level with the 4-bit mask supplied by the CPU. It registers three outputs: a request flag, the winning level and a 12-bit event code that names the exact source. Software can use the event code directly as a branch offset. Once a request is presented, it stays frozen until the CPU pulses the acknowledge input. The mask is only an input, so taking an interrupt never changes it.

A separate wake output is used during standby. Only external lines 0 and 1 and the timer and real-time-clock peripheral lines can raise it.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A source requests only while its input is high. After an acknowledge, with no input high, `irq_req` is low one cycle later.
- R2: External lines 0–7 take their level from write register 0 bits [3:0]. Lines 8–15 take theirs from register 0 bits [7:4]. Each field is shared by all eight lines of its group.
- R3: `irq_req` rises only when the winning level is strictly greater than `cpu_mask`.
- R4: Peripheral line j (j = 0..NPER-1) takes its level from its own field. That field is field number 2+j, held in register (2+j)/4 at bits [4*((2+j)%4)+3 : 4*((2+j)%4)].
- R5: A source whose level is 0 never produces a request, whatever the mask.
- R6: The debug request always has level 15. No register write can change that level.
- R7: When several active sources share the highest level, the lowest source index wins. The index order is external lines 0–15 (indices 0–15), then peripheral lines (index 16+j), then debug (index 16+NPER).
- R8: `evt_code` equals 0x200 + 0x20 × winning index. `evt_code`, `irq_lvl` and `irq_req` are registered, so they appear one cycle after their inputs. While `irq_req` is high they hold until the cycle in which `irq_ack` is high. In that cycle the block reloads from the current arbitration.
- R9: `wake` is high one cycle after `standby` and `lfclk_en` are both high while a wake-capable active source has a level strictly greater than `cpu_mask`. It is low otherwise.
- R10: Only external lines 0 and 1, peripheral line TMR_SLOT (default 0, timer) and peripheral line RTC_SLOT (default 1, real-time clock) are wake-capable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq | input | 16 | Level-sensitive external requests, active high |
| per_req | input | NPER | Internal peripheral requests, active high |
| dbg_req | input | 1 | Debug request at fixed level 15 |
| cpu_mask | input | 4 | CPU interrupt mask level |
| wr_en | input | 1 | Priority register write strobe |
| wr_addr | input | AW | Priority register select |
| wr_data | input | 16 | Four 4-bit priority fields |
| irq_ack | input | 1 | Acknowledge pulse that releases the held request |
| standby | input | 1 | Chip is in standby |
| lfclk_en | input | 1 | Low-frequency clock running |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_lvl | output | 4 | Level of the presented request |
| evt_code | output | 12 | Event code of the presented source |
| wake | output | 1 | Wake-up request during standby |

## Verification
On every cycle the assertions check four things. A new request always sits above the mask seen when it was taken. A presented level is never zero. The request, level and code stay frozen until acknowledge. Wake only follows a cycle with both standby and the low-frequency clock enabled. Some behaviour needs directed scenarios that know the register layout and the expected source numbering. These are the mapping of groups and peripheral fields, the lowest-index tie rule, the exact event code values, the fixed debug level and which sources may wake the chip.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int LVL_W     = 4;
  localparam int CODE_W    = 12;
  localparam int EXT_N     = 16;
  localparam int GRP_N     = 2;
  localparam int FPR       = 4;              // fields per register
  localparam int REG_W     = FPR * LVL_W;
  localparam int CODE_BASE = 'h200;
  localparam int CODE_SHFT = 5;              // step of 0x20 per source
  localparam logic [LVL_W-1:0] DBG_LVL = '1;

  function automatic logic [CODE_W-1:0] evt_of(input int idx);
    return CODE_W'(CODE_BASE + (idx << CODE_SHFT));
  endfunction
endpackage

// File: rtl/intc_prio_regs.sv
module intc_prio_regs
  import intc_pkg::*;
#(
  parameter int NFLD = 10,
  parameter int NREG = (NFLD + FPR - 1) / FPR,
  parameter int AW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [AW-1:0]               wr_addr,
  input  logic [REG_W-1:0]            wr_data,
  output logic [NFLD-1:0][LVL_W-1:0]  fld_o
);
  logic [NREG*FPR-1:0][LVL_W-1:0] regs_q, regs_d;
  logic                           wr_hit;

  assign wr_hit = wr_en && (int'(wr_addr) < NREG);

  always_comb begin
    regs_d = regs_q;
    for (int r = 0; r < NREG; r++) begin
      if (wr_hit && (int'(wr_addr) == r)) begin
        for (int f = 0; f < FPR; f++) begin
          regs_d[r*FPR+f] = wr_data[f*LVL_W +: LVL_W];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs_q <= '0;
    else        regs_q <= regs_d;
  end

  for (genvar g = 0; g < NFLD; g++) begin : g_fld
    assign fld_o[g] = regs_q[g];
  end
endmodule

// File: rtl/intc_arb.sv
module intc_arb
  import intc_pkg::*;
#(
  parameter int NSRC = 25,
  parameter int IW   = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]             act_i,
  input  logic [NSRC-1:0][LVL_W-1:0]  lvl_i,
  output logic                        win_vld,
  output logic [IW-1:0]               win_idx,
  output logic [LVL_W-1:0]            win_lvl
);
  // Scan from the top index down; ">=" lets the lowest index win a tie.
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (act_i[i] && (lvl_i[i] != '0) && (lvl_i[i] >= win_lvl)) begin
        win_vld = 1'b1;
        win_idx = IW'(i);
        win_lvl = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/intc_wake.sv
module intc_wake
  import intc_pkg::*;
#(
  parameter int NW = 4
) (
  input  logic [NW-1:0]             cand_act,
  input  logic [NW-1:0][LVL_W-1:0]  cand_lvl,
  input  logic [LVL_W-1:0]          mask_i,
  output logic                      hit_o
);
  always_comb begin
    hit_o = 1'b0;
    for (int i = 0; i < NW; i++) begin
      if (cand_act[i] && (cand_lvl[i] > mask_i)) hit_o = 1'b1;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import intc_pkg::*;
#(
  parameter int NPER     = 8,
  parameter int TMR_SLOT = 0,
  parameter int RTC_SLOT = 1,
  parameter int NFLD     = GRP_N + NPER,
  parameter int NREG     = (NFLD + FPR - 1) / FPR,
  parameter int AW       = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EXT_N-1:0]  ext_irq,
  input  logic [NPER-1:0]   per_req,
  input  logic              dbg_req,
  input  logic [LVL_W-1:0]  cpu_mask,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              irq_ack,
  input  logic              standby,
  input  logic              lfclk_en,
  output logic              irq_req,
  output logic [LVL_W-1:0]  irq_lvl,
  output logic [CODE_W-1:0] evt_code,
  output logic              wake
);
  localparam int NSRC    = EXT_N + NPER + 1;
  localparam int IW      = $clog2(NSRC);
  localparam int GRP_SZ  = EXT_N / GRP_N;
  localparam int DBG_IDX = NSRC - 1;
  localparam int NW      = 4;

  logic [NFLD-1:0][LVL_W-1:0] fld;
  logic [NSRC-1:0][LVL_W-1:0] src_lvl;
  logic [NSRC-1:0]            src_act;
  logic                       win_vld;
  logic [IW-1:0]              win_idx;
  logic [LVL_W-1:0]           win_lvl;
  logic [NW-1:0]              w_act;
  logic [NW-1:0][LVL_W-1:0]   w_lvl;
  logic                       w_hit;

  logic              req_q, req_d, load_en;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              wake_q, wake_d;

  intc_prio_regs #(.NFLD(NFLD), .NREG(NREG), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fld_o(fld)
  );

  // Source table: external lines, peripherals, debug last.
  for (genvar g = 0; g < EXT_N; g++) begin : g_ext
    assign src_lvl[g] = fld[g / GRP_SZ];
  end
  for (genvar p = 0; p < NPER; p++) begin : g_per
    assign src_lvl[EXT_N+p] = fld[GRP_N+p];
  end
  assign src_lvl[DBG_IDX] = DBG_LVL;
  assign src_act = {dbg_req, per_req, ext_irq};

  intc_arb #(.NSRC(NSRC), .IW(IW)) u_arb (
    .act_i(src_act), .lvl_i(src_lvl),
    .win_vld(win_vld), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  assign w_act = {per_req[RTC_SLOT], per_req[TMR_SLOT], ext_irq[1], ext_irq[0]};
  assign w_lvl = {src_lvl[EXT_N+RTC_SLOT], src_lvl[EXT_N+TMR_SLOT],
                  src_lvl[1], src_lvl[0]};

  intc_wake #(.NW(NW)) u_wake (
    .cand_act(w_act), .cand_lvl(w_lvl), .mask_i(cpu_mask), .hit_o(w_hit)
  );

  // Next state
  always_comb begin
    load_en = !req_q || irq_ack;
    req_d   = req_q;
    lvl_d   = lvl_q;
    code_d  = code_q;
    if (load_en) begin
      req_d = win_vld && (win_lvl > cpu_mask);
      lvl_d = req_d ? win_lvl : '0;
      if (req_d) code_d = evt_of(int'(win_idx));
    end
    wake_d = standby && lfclk_en && w_hit;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      lvl_q  <= '0;
      code_q <= '0;
      wake_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      lvl_q  <= lvl_d;
      code_q <= code_d;
      wake_q <= wake_d;
    end
  end

  assign irq_req  = req_q;
  assign irq_lvl  = lvl_q;
  assign evt_code = code_q;
  assign wake     = wake_q;

  AST_RISE_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> (irq_lvl > $past(cpu_mask)));                   // R3
  AST_LVL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_lvl != '0));                                      // R5
  AST_HOLD_TO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> (irq_req && $stable(evt_code) && $stable(irq_lvl))); // R8
  AST_CODE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((evt_code[CODE_SHFT-1:0] == '0) && (int'(evt_code) >= CODE_BASE))); // R8
  AST_DBG_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && (cpu_mask != DBG_LVL) && !irq_req) |=> irq_req);        // R6
  AST_WAKE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(standby && lfclk_en));                              // R9
endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int NPER  = 8;
  localparam int AW    = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] ext_irq;
  logic [NPER-1:0] per_req;
  logic        dbg_req;
  logic [3:0]  cpu_mask;
  logic        wr_en;
  logic [AW-1:0] wr_addr;
  logic [15:0] wr_data;
  logic        irq_ack, standby, lfclk_en;
  logic        irq_req, wake;
  logic [3:0]  irq_lvl;
  logic [11:0] evt_code;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  irq_prio_ctrl #(.NPER(NPER)) u_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .per_req(per_req),
    .dbg_req(dbg_req), .cpu_mask(cpu_mask), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq_ack(irq_ack), .standby(standby), .lfclk_en(lfclk_en),
    .irq_req(irq_req), .irq_lvl(irq_lvl), .evt_code(evt_code), .wake(wake)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(input int a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic clear_all();
    ext_irq = '0; per_req = '0; dbg_req = 1'b0; cpu_mask = '0;
    irq_ack = 1'b1;
    step();
    irq_ack = 1'b0;
    step();
  endtask

  task automatic t_reset();
    chk("R1 reset irq_req", int'(irq_req), 0);
    chk("R9 reset wake", int'(wake), 0);
    chk("R8 reset evt_code", int'(evt_code), 0);
  endtask

  task automatic t_zero_prio();
    ext_irq = 16'h0001; per_req = 8'hFF;
    step(); step();
    chk("R5 level zero no request", int'(irq_req), 0);
    clear_all();
  endtask

  task automatic t_groups();
    wr_reg(0, 16'h0095);             // R2 group lo=5, group hi=9
    ext_irq = 16'h0004;
    step();
    chk("R2 low group level", int'(irq_lvl), 5);
    chk("R8 code of line 2", int'(evt_code), 'h240);
    clear_all();
    ext_irq = 16'h0400;
    step();
    chk("R2 high group level", int'(irq_lvl), 9);
    chk("R8 code of line 10", int'(evt_code), 'h340);
    clear_all();
  endtask

  task automatic t_mask();
    ext_irq = 16'h0400; cpu_mask = 4'd9;
    step();
    chk("R3 level equal to mask blocked", int'(irq_req), 0);
    cpu_mask = 4'd8;
    step();
    chk("R3 level above mask taken", int'(irq_req), 1);
    clear_all();
  endtask

  task automatic t_periph();
    wr_reg(1, 16'h00C0);             // R4 peripheral 3 -> reg1 [7:4]
    per_req = 8'h08;
    step();
    chk("R4 peripheral own level", int'(irq_lvl), 12);
    chk("R8 code of peripheral 3", int'(evt_code), 'h460);
    clear_all();
  endtask

  task automatic t_debug();
    wr_reg(2, 16'hFFFF);
    dbg_req = 1'b1; cpu_mask = 4'd14;
    step();
    chk("R6 debug request", int'(irq_req), 1);
    chk("R6 debug level fixed", int'(irq_lvl), 15);
    chk("R8 code of debug", int'(evt_code), 'h500);
    clear_all();
    wr_reg(2, 16'h0000);
  endtask

  task automatic t_tie();
    ext_irq = 16'h0028;              // lines 3 and 5, both level 5
    step();
    chk("R7 lowest index wins", int'(evt_code), 'h260);
    clear_all();
  endtask

  task automatic t_hold();
    ext_irq = 16'h0400;
    step();
    chk("R8 initial code", int'(evt_code), 'h340);
    ext_irq = '0; per_req = 8'h08;   // higher level source appears
    step();
    chk("R8 code held", int'(evt_code), 'h340);
    chk("R8 level held", int'(irq_lvl), 9);
    irq_ack = 1'b1;
    step();
    irq_ack = 1'b0;
    chk("R8 reload after ack", int'(evt_code), 'h460);
    per_req = '0;
    irq_ack = 1'b1;
    step();
    irq_ack = 1'b0;
    chk("R1 request gone with input", int'(irq_req), 0);
    clear_all();
  endtask

  task automatic t_wake();
    wr_reg(0, 16'h0605);             // lo=5, hi=0, timer field=6
    standby = 1'b1; lfclk_en = 1'b1; cpu_mask = 4'd3;
    ext_irq = 16'h0002;
    step();
    chk("R9 wake from line 1", int'(wake), 1);
    lfclk_en = 1'b0;
    step();
    chk("R9 no wake without slow clock", int'(wake), 0);
    lfclk_en = 1'b1; standby = 1'b0;
    step();
    chk("R9 no wake outside standby", int'(wake), 0);
    standby = 1'b1; ext_irq = 16'h0004;
    step();
    chk("R10 line 2 cannot wake", int'(wake), 0);
    ext_irq = '0; per_req = 8'h01;
    step();
    chk("R10 timer wakes", int'(wake), 1);
    cpu_mask = 4'd6;
    step();
    chk("R9 level equal to mask no wake", int'(wake), 0);
    standby = 1'b0;
    clear_all();
  endtask

  initial begin
    rst_n = 1'b0; ext_irq = '0; per_req = '0; dbg_req = 1'b0; cpu_mask = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; irq_ack = 1'b0;
    standby = 1'b0; lfclk_en = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_zero_prio();
    t_groups();
    t_mask();
    t_periph();
    t_debug();
    t_tie();
    t_hold();
    t_wake();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule